// File: doc/BRIEF.md
# Serial Perceptron Layer Engine

This block evaluates one fully connected perceptron layer with a single multiply-accumulate datapath that is shared by every neuron. An input vector arrives one element per cycle. The first element carries a start marker. The block stores the vector locally, then walks the neurons in turn. For each neuron it accumulates weight-times-input products, adds that neuron's bias and passes the sum through a clamped linear sigmoid approximation. It places each neuron's result on the output stream in neuron order. The output stream is framed by a first flag and a last flag, so a downstream layer of the same kind can take it as its input vector.

All values are 24-bit two's-complement fixed point with 16 fraction bits, so 1.0 is encoded as 65536. Weights and biases live in two separate local memories. These are loaded through one write port that only takes effect while the layer is idle. The sequencer has four states:

- IDLE waits for a start-marked element. It goes to CAPTURE, or straight to ACCUM when the vector length is one.
- CAPTURE stores elements and returns to its first slot on a new start marker. It goes to ACCUM when the final element is stored.
- ACCUM runs one product per cycle. After the last input index it goes to FINISH.
- FINISH adds the bias, applies the activation and registers the result. It goes back to ACCUM for the next neuron, or to IDLE after the last neuron.

Top module: `nlpu_layer`

## Requirements
- R1: While reset is held and after its release, out_valid, out_first, out_last and out_data are all 0 until a vector has been processed.
- R2: Each neuron j yields act(sat(acc + b[j])), where acc starts at 0. For each input index i in order, acc = sat(acc + floor(w[j*N_IN+i] * x[i] / 65536)), with all operands 24-bit Q8.16.
- R3: Every accumulation and the bias addition saturate to [-8388608, 8388607] instead of wrapping. A sum that overshoots and then comes back is therefore clipped first.
- R4: The activation is y = 32768 + floor(z / 4), clamped to [0, 65536]: 0.5 at zero input, 0 at or below -2.0, and 1.0 at or above +2.0.
- R5: A processed vector produces exactly N_NEU one-cycle out_valid pulses in neuron order. out_first is set only with neuron 0 and out_last only with neuron N_NEU-1, and both flags appear only together with out_valid.
- R6: A vector starts only on in_valid with in_first = 1 while idle. An in_valid element without in_first while idle is discarded and starts nothing.
- R7: in_first during capture restarts the vector: the marked element becomes element 0, and elements taken earlier are discarded.
- R8: Input elements (marked or not) presented while the layer is computing are ignored and do not start a new vector.
- R9: Configuration write with cfg_bias = 0 stores cfg_data to weight index cfg_addr = j*N_IN + i. With cfg_bias = 1 it stores cfg_data to the bias of neuron cfg_addr. A write presented outside IDLE has no effect.
- R10: Two out_valid pulses are never on adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element present |
| in_first | input | 1 | Input element is element 0 of a vector |
| in_data | input | 24 | Input element, Q8.16 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bias | input | 1 | 1 selects the bias memory, 0 the weight memory |
| cfg_addr | input | AW | Weight index or neuron index |
| cfg_data | input | 24 | Value written, Q8.16 |
| out_valid | output | 1 | Neuron result present |
| out_first | output | 1 | Result belongs to neuron 0 |
| out_last | output | 1 | Result belongs to the last neuron |
| out_data | output | 24 | Neuron result, Q8.16 in [0, 1.0] |

## Verification
The last result of one vector and the sequencer's return to IDLE happen on the same edge. A new vector start and a configuration write can therefore land in the very cycle where out_last is presented. The bench holds a start marker and a write to one weight asserted throughout a computation. In the cycle where out_last shows, it switches to the first element of a fresh vector and a write to a different weight. The following vector's results show that the held write and the held inputs were dropped, and that both same-cycle actions were taken. A bench-side arithmetic model computes each expected result from the requirements.

// File: rtl/nlpu_pkg.sv
package nlpu_pkg;

    localparam int QW = 24;
    localparam int QF = 16;

    localparam longint QMAX    = (longint'(1) <<< (QW - 1)) - 1;
    localparam longint QMIN    = -(longint'(1) <<< (QW - 1));
    localparam longint Q_ONE   = longint'(1) <<< QF;
    localparam longint Q_HALF  = longint'(1) <<< (QF - 1);

    typedef logic signed [QW-1:0] q_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_ACCUM   = 2'd2,
        ST_FINISH  = 2'd3
    } st_e;

    function automatic longint q_widen(input q_t v);
        return longint'(v);
    endfunction

    function automatic q_t q_sat(input longint v);
        longint c;
        if (v > QMAX)      c = QMAX;
        else if (v < QMIN) c = QMIN;
        else               c = v;
        return q_t'(c[QW-1:0]);
    endfunction

    // Linear sigmoid stand-in: 0.5 + z/4, held inside [0, 1.0]
    function automatic q_t q_hard_sigmoid(input q_t z);
        longint t;
        t = Q_HALF + (q_widen(z) >>> 2);
        if (t < 0)          t = 0;
        else if (t > Q_ONE) t = Q_ONE;
        return q_t'(t[QW-1:0]);
    endfunction

endpackage

// File: rtl/nlpu_coef_store.sv
module nlpu_coef_store
    import nlpu_pkg::*;
#(
    parameter int N_IN  = 30,
    parameter int N_NEU = 3,
    localparam int NW   = N_IN * N_NEU,
    localparam int AW   = (NW > 1) ? $clog2(NW) : 1,
    localparam int NNW  = (N_NEU > 1) ? $clog2(N_NEU) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_bias,
    input  logic [AW-1:0]  wr_addr,
    input  q_t             wr_data,
    input  logic [AW-1:0]  w_raddr,
    input  logic [NNW-1:0] b_raddr,
    output q_t             w_rdata,
    output q_t             b_rdata
);

    q_t wmem [NW];
    q_t bmem [N_NEU];

    // weight bank and bias bank are separate so both read in one cycle
    for (genvar k = 0; k < NW; k++) begin : g_w
        always_ff @(posedge clk) begin
            if (!rst_n)
                wmem[k] <= '0;
            else if (wr_en && !wr_bias && wr_addr == AW'(k))
                wmem[k] <= wr_data;
        end
    end

    for (genvar k = 0; k < N_NEU; k++) begin : g_b
        always_ff @(posedge clk) begin
            if (!rst_n)
                bmem[k] <= '0;
            else if (wr_en && wr_bias && wr_addr == AW'(k))
                bmem[k] <= wr_data;
        end
    end

    assign w_rdata = wmem[w_raddr];
    assign b_rdata = bmem[b_raddr];

endmodule

// File: rtl/nlpu_mac.sv
module nlpu_mac
    import nlpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic acc_en,
    input  q_t   w,
    input  q_t   x,
    input  q_t   b,
    output q_t   biased
);

    q_t     acc;
    longint prod_q;

    // full 48-bit product, then drop the fraction bits (floor)
    assign prod_q = (q_widen(w) * q_widen(x)) >>> QF;

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (clr)
            acc <= '0;
        else if (acc_en)
            acc <= q_sat(q_widen(acc) + prod_q);
    end

    assign biased = q_sat(q_widen(acc) + q_widen(b));

endmodule

// File: rtl/nlpu_act.sv
module nlpu_act
    import nlpu_pkg::*;
(
    input  q_t z,
    output q_t y
);

    assign y = q_hard_sigmoid(z);

endmodule

// File: rtl/nlpu_layer.sv
module nlpu_layer
    import nlpu_pkg::*;
#(
    parameter int N_IN  = 30,
    parameter int N_NEU = 3,
    localparam int NW   = N_IN * N_NEU,
    localparam int AW   = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_first,
    input  logic [23:0]   in_data,
    input  logic          cfg_we,
    input  logic          cfg_bias,
    input  logic [AW-1:0] cfg_addr,
    input  logic [23:0]   cfg_data,
    output logic          out_valid,
    output logic          out_first,
    output logic          out_last,
    output logic [23:0]   out_data
);

    localparam int NIW = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int NNW = (N_NEU > 1) ? $clog2(N_NEU) : 1;

    st_e            st, st_nx;
    q_t             xbuf [N_IN];
    logic [NIW-1:0] cap_idx;
    logic [NIW-1:0] in_idx;
    logic [NNW-1:0] neu_idx;

    logic           start_hit;
    logic           cap_last;
    logic           acc_last;
    logic           neu_last;
    logic           cfg_ok;
    logic           mac_clr;
    logic           mac_en;
    logic [AW-1:0]  w_raddr;
    q_t             w_rd, b_rd, x_rd, biased, act_y;

    assign start_hit = in_valid && in_first;
    assign cap_last  = (cap_idx == NIW'(N_IN - 1));
    assign acc_last  = (in_idx == NIW'(N_IN - 1));
    assign neu_last  = (neu_idx == NNW'(N_NEU - 1));
    assign cfg_ok    = cfg_we && (st == ST_IDLE);

    // ---------------- state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // ---------------- next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (start_hit)
                    st_nx = (N_IN == 1) ? ST_ACCUM : ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (in_valid && !in_first && cap_last)
                    st_nx = ST_ACCUM;
            end
            ST_ACCUM: begin
                if (acc_last)
                    st_nx = ST_FINISH;
            end
            ST_FINISH: begin
                st_nx = neu_last ? ST_IDLE : ST_ACCUM;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // ---------------- index counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_idx <= '0;
            in_idx  <= '0;
            neu_idx <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    in_idx  <= '0;
                    neu_idx <= '0;
                    if (start_hit)
                        cap_idx <= NIW'(1);
                end
                ST_CAPTURE: begin
                    if (in_valid)
                        cap_idx <= in_first ? NIW'(1) : cap_idx + NIW'(1);
                end
                ST_ACCUM: begin
                    in_idx <= acc_last ? '0 : in_idx + NIW'(1);
                end
                ST_FINISH: begin
                    neu_idx <= neu_idx + NNW'(1);
                end
                default: ;
            endcase
        end
    end

    // ---------------- input vector buffer
    always_ff @(posedge clk) begin
        if (st == ST_IDLE && start_hit)
            xbuf[0] <= q_t'(in_data);
        else if (st == ST_CAPTURE && in_valid)
            xbuf[in_first ? '0 : cap_idx] <= q_t'(in_data);
    end

    // ---------------- datapath
    assign w_raddr = AW'(int'(neu_idx) * N_IN + int'(in_idx));
    assign x_rd    = xbuf[in_idx];
    assign mac_en  = (st == ST_ACCUM);
    assign mac_clr = (st == ST_IDLE) || (st == ST_FINISH) ||
                     (st == ST_CAPTURE && start_hit);

    nlpu_coef_store #(.N_IN(N_IN), .N_NEU(N_NEU)) coef_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_ok),
        .wr_bias (cfg_bias),
        .wr_addr (cfg_addr),
        .wr_data (q_t'(cfg_data)),
        .w_raddr (w_raddr),
        .b_raddr (neu_idx),
        .w_rdata (w_rd),
        .b_rdata (b_rd)
    );

    nlpu_mac mac_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (mac_clr),
        .acc_en (mac_en),
        .w      (w_rd),
        .x      (x_rd),
        .b      (b_rd),
        .biased (biased)
    );

    nlpu_act act_i (
        .z (biased),
        .y (act_y)
    );

    // ---------------- output serializer and framing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= (st == ST_FINISH);
            out_first <= (st == ST_FINISH) && (neu_idx == '0);
            out_last  <= (st == ST_FINISH) && neu_last;
            if (st == ST_FINISH)
                out_data <= act_y;
        end
    end

endmodule

// File: rtl/nlpu_layer_chk.sv
module nlpu_layer_chk
    import nlpu_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_first,
    input logic                 out_valid,
    input logic                 out_first,
    input logic                 out_last,
    input logic signed [QW-1:0] out_data,
    input st_e                  st
);

    AST_ACT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data >= 0 && longint'(out_data) <= Q_ONE)); // R4

    AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_first || out_last) |-> out_valid); // R5

    AST_RESULT_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(st) == ST_FINISH)); // R5

    AST_LAST_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (st == ST_IDLE)); // R8

    AST_CAPTURE_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_IDLE && st != ST_IDLE) |-> $past(in_valid && in_first)); // R6

    AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R10

endmodule

bind nlpu_layer nlpu_layer_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .out_valid (out_valid),
    .out_first (out_first),
    .out_last  (out_last),
    .out_data  (out_data),
    .st        (st)
);

// File: tb/nlpu_layer_tb_top.sv
module nlpu_layer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_IN  = 4;
    localparam int N_NEU = 3;
    localparam int NW    = N_IN * N_NEU;
    localparam int AW    = $clog2(NW);
    localparam longint QMAX = 8388607;
    localparam longint QMIN = -8388608;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_first;
    logic [23:0]   in_data;
    logic          cfg_we, cfg_bias;
    logic [AW-1:0] cfg_addr;
    logic [23:0]   cfg_data;
    logic          out_valid, out_first, out_last;
    logic [23:0]   out_data;

    int n_vec = 0;
    int n_bad = 0;

    longint Wm [NW];
    longint Bm [N_NEU];
    longint Xv [N_IN];
    longint seed = 64'd12345;

    nlpu_layer #(.N_IN(N_IN), .N_NEU(N_NEU)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_first(in_first), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_bias(cfg_bias), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_first(out_first), .out_last(out_last), .out_data(out_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint clampv(input longint v, input longint lo, input longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic longint ref_out(input int j);
        longint acc = 0;
        for (int i = 0; i < N_IN; i++)
            acc = clampv(acc + ((Wm[j*N_IN+i] * Xv[i]) >>> 16), QMIN, QMAX);
        acc = clampv(acc + Bm[j], QMIN, QMAX);
        return clampv(32768 + (acc >>> 2), 0, 65536);
    endfunction

    function automatic longint rnd_q(input longint span);
        seed = (seed * 1103515245 + 12345) & 64'h7fffffff;
        return (seed % (2 * span * 65536)) - span * 65536;
    endfunction

    // all tasks start and end just after a falling edge
    task automatic wr(input bit is_b, input int addr, input longint val);
        cfg_we = 1'b1; cfg_bias = is_b; cfg_addr = AW'(addr); cfg_data = val[23:0];
        @(negedge clk);
        cfg_we = 1'b0;
        if (is_b) Bm[addr] = val; else Wm[addr] = val;
    endtask

    task automatic load_all();
        for (int k = 0; k < NW; k++) wr(1'b0, k, Wm[k]);
        for (int k = 0; k < N_NEU; k++) wr(1'b1, k, Bm[k]);
    endtask

    task automatic send_vec();
        for (int i = 0; i < N_IN; i++) begin
            in_valid = 1'b1; in_first = (i == 0); in_data = Xv[i][23:0];
            @(negedge clk);
        end
        in_valid = 1'b0; in_first = 1'b0;
    endtask

    task automatic take(input string req, input int got);
        chk(req, longint'($signed(out_data)), ref_out(got));
        chk("R5 first", longint'(out_first), longint'(got == 0));
        chk("R5 last", longint'(out_last), longint'(got == N_NEU - 1));
    endtask

    task automatic collect(input string req);
        int  got = 0;
        bit  prev = 1'b0;
        for (int t = 0; t < 400 && got < N_NEU; t++) begin
            if (out_valid) begin
                take(req, got);
                chk("R10 gap", longint'(prev), 0);
                got++;
            end
            prev = out_valid;
            @(negedge clk);
        end
        chk("R5 count", got, N_NEU);
    endtask

    task automatic quiet(input string req, input int n);
        int seen = 0;
        for (int t = 0; t < n; t++) begin
            if (out_valid) seen++;
            @(negedge clk);
        end
        chk(req, seen, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_vec++; n_bad++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_data = '0;
        cfg_we = 1'b0; cfg_bias = 1'b0; cfg_addr = '0; cfg_data = '0;
        for (int k = 0; k < NW; k++) Wm[k] = 0;
        for (int k = 0; k < N_NEU; k++) Bm[k] = 0;
        repeat (3) @(negedge clk);
        chk("R1 valid", longint'(out_valid), 0);
        chk("R1 data", longint'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags", longint'({out_first, out_last}), 0);

        // R4: zero weights, bias sets the activation input directly
        for (int i = 0; i < N_IN; i++) Xv[i] = 65536 * (i + 1);
        Bm[0] = 0; Bm[1] = 65536; Bm[2] = -3 * 65536;
        load_all();
        send_vec();
        collect("R4 activation");

        // R2/R9: sweep of small, medium and large operand ranges
        for (int v = 0; v < 24; v++) begin
            longint span = (v % 3 == 0) ? 2 : ((v % 3 == 1) ? 16 : 127);
            for (int k = 0; k < NW; k++) Wm[k] = rnd_q(span);
            for (int k = 0; k < N_NEU; k++) Bm[k] = rnd_q(span);
            for (int i = 0; i < N_IN; i++) Xv[i] = rnd_q(span);
            load_all();
            send_vec();
            collect("R2 R9 sweep");
        end

        // R3: overshoot then return must stay clipped
        Xv[0] = 100 * 65536; Xv[1] = 100 * 65536; Xv[2] = -100 * 65536; Xv[3] = 0;
        for (int i = 0; i < N_IN; i++) begin
            Wm[i] = (i < 3) ? 100 * 65536 : 0;
            Wm[N_IN + i] = 0;
            Wm[2*N_IN + i] = 65536;
        end
        for (int k = 0; k < N_NEU; k++) Bm[k] = 0;
        load_all();
        send_vec();
        collect("R3 saturation");

        // R6: unmarked elements while idle start nothing
        for (int t = 0; t < 5; t++) begin
            in_valid = 1'b1; in_first = 1'b0; in_data = 24'h012345;
            @(negedge clk);
        end
        in_valid = 1'b0;
        quiet("R6 no start", 40);
        for (int i = 0; i < N_IN; i++) Xv[i] = rnd_q(4);
        send_vec();
        collect("R6 after stray");

        // R7: restart in the middle of capture
        in_valid = 1'b1; in_first = 1'b1; in_data = 24'h7ff000;
        @(negedge clk);
        in_first = 1'b0; in_data = 24'h7ff000;
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < N_IN; i++) Xv[i] = rnd_q(4);
        send_vec();
        collect("R7 restart");

        // R8/R9: held inputs and writes while busy, then same-cycle start + write
        for (int k = 0; k < NW; k++) Wm[k] = rnd_q(3);
        load_all();
        for (int i = 0; i < N_IN; i++) Xv[i] = rnd_q(3);
        send_vec();
        begin
            int got = 0;
            for (int t = 0; t < 400; t++) begin
                if (out_valid) begin
                    take("R8 busy run", got);
                    got++;
                    if (out_last) break;
                end
                in_valid = 1'b1; in_first = 1'b1; in_data = 24'h3c0000;
                cfg_we = 1'b1; cfg_bias = 1'b0; cfg_addr = AW'(0); cfg_data = 24'h500000;
                @(negedge clk);
            end
            chk("R5 busy count", got, N_NEU);
        end
        // out_last is showing: sequencer is idle on the next edge
        for (int i = 0; i < N_IN; i++) Xv[i] = 65536 + rnd_q(1);
        Xv[0] = 2 * 65536;
        in_valid = 1'b1; in_first = 1'b1; in_data = Xv[0][23:0];
        cfg_we = 1'b1; cfg_bias = 1'b0; cfg_addr = AW'(1); cfg_data = 24'h00c000;
        Wm[1] = 24'h00c000;
        @(negedge clk);
        cfg_we = 1'b0;
        for (int i = 1; i < N_IN; i++) begin
            in_valid = 1'b1; in_first = 1'b0; in_data = Xv[i][23:0];
            @(negedge clk);
        end
        in_valid = 1'b0;
        collect("R9 idle-only write");
        quiet("R8 no extra vector", 3 * N_IN + 10);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule